// File: doc/BRIEF.md
# Real-Time Clock Interrupt Event Status

This block gathers the three event sources of a real-time clock and reports them to software. The sources are the end of an update cycle, an alarm match and a periodic tick. Each source arrives as a one-cycle pulse. The block holds each pulse in a sticky flag, and the flag stays set until software reads the event status byte. The flags are latched whatever the state of the enables.

Three enable inputs choose which flags may raise an interrupt. The summary request bit is the OR of each flag ANDed with its own enable. That bit drives an active-low request line. The request is formed only from the flags, so a read that clears the flags also drops the line.

A second read-only byte reports whether the backup supply is valid. The timekeeping counters, the alarm comparator and the periodic divider are not part of this block. They are represented only by their pulses.

Top module: `rtc_evt_status`

## Requirements
- R1: After reset, both status bytes read 0x00 and `irq_n` is 1.
- R2: A pulse on `upd_evt`, `alm_evt` or `per_evt` sets its flag whatever the enables are. The flag shows in the next event byte read.
- R3: The event byte read on a strobe edge has this layout: bit 7 is the request bit, bit 6 is the periodic flag, bit 5 is the alarm flag, bit 4 is the update flag, and bits 3..0 are 0.
- R4: The request bit equals (upd_en AND update flag) OR (alm_en AND alarm flag) OR (per_en AND periodic flag).
- R5: `irq_n` is the inverse of the request bit. It reacts in the same cycle that an enable changes while its flag is pending.
- R6: A read of the event byte clears all flags, and therefore the request. A second read with no new events returns 0x00.
- R7: When a pulse coincides with an event byte read, the read returns the value from before that event. The pulse's flag stays set after the read.
- R8: On an integrity read, bit 7 captures `bkp_ok` and bits 6..0 are 0.
- R9: Each status byte holds its captured value until its own read strobe is high again.
- R10: An integrity read leaves the event flags and `irq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_evt | input | 1 | Update-cycle-complete pulse |
| alm_evt | input | 1 | Alarm match pulse |
| per_evt | input | 1 | Periodic tick pulse |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| evt_rd | input | 1 | Event byte read strobe (captures, then clears flags) |
| integ_rd | input | 1 | Integrity byte read strobe |
| bkp_ok | input | 1 | Backup supply valid level |
| evt_byte | output | 8 | Captured event status byte |
| integ_byte | output | 8 | Captured integrity status byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag that is wrongly held or wrongly cleared shows up in two places. `irq_n` is wrong within the same cycle if the source is enabled, and the event byte is wrong on the very next read. A clear that fails shows as a nonzero second read. A coincident pulse that is lost shows as a zero byte on the read after it. A layout error shows on the first read in which any single source is set. The sweep over every combination of pulses and enables therefore exposes each such fault within two reads.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  // Number of event sources. Index 0 is update, 1 is alarm, 2 is periodic.
  localparam int unsigned N_SRC   = 3;
  localparam int unsigned SRC_UPD = 0;
  localparam int unsigned SRC_ALM = 1;
  localparam int unsigned SRC_PER = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_evt_flag.sv
// One sticky event flag: set by a pulse, cleared by a read strobe.
// A pulse wins over a clear in the same cycle.
module rtc_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_o <= 1'b0;
    else
      flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/rtc_irq_merge.sv
// Merges flag/enable pairs into a single request bit.
module rtc_irq_merge #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         req_o
);
  assign req_o = |(flag_i & en_i);
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status
  import rtc_evt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_evt,
  input  logic              alm_evt,
  input  logic              per_evt,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic              evt_rd,
  input  logic              integ_rd,
  input  logic              bkp_ok,
  output logic [BYTE_W-1:0] evt_byte,
  output logic [BYTE_W-1:0] integ_byte,
  output logic              irq_n
);
  // The request bit sits at the top, with the sources packed directly below it.
  localparam int unsigned REQ_BIT = BYTE_W - 1;
  localparam int unsigned SRC_LSB = BYTE_W - 1 - N_SRC;

  src_vec_t pulse_v, en_v, flag_v;
  logic     req;

  assign pulse_v[SRC_UPD] = upd_evt;
  assign pulse_v[SRC_ALM] = alm_evt;
  assign pulse_v[SRC_PER] = per_evt;
  assign en_v[SRC_UPD]    = upd_en;
  assign en_v[SRC_ALM]    = alm_en;
  assign en_v[SRC_PER]    = per_en;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    rtc_evt_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (pulse_v[g]),
      .clr_i  (evt_rd),
      .flag_o (flag_v[g])
    );
  end

  rtc_irq_merge #(.N(N_SRC)) u_merge (
    .flag_i (flag_v),
    .en_i   (en_v),
    .req_o  (req)
  );

  // Event byte: capture the flags from before the edge, on the same edge that clears them.
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_byte <= '0;
    end else if (evt_rd) begin
      evt_byte                           <= '0;
      evt_byte[REQ_BIT]                  <= req;
      evt_byte[SRC_LSB +: N_SRC]         <= flag_v;
    end
  end

  // Integrity byte: backup-valid level in the top bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      integ_byte <= '0;
    end else if (integ_rd) begin
      integ_byte          <= '0;
      integ_byte[REQ_BIT] <= bkp_ok;
    end
  end

  assign irq_n = ~req;
endmodule

// File: rtl/rtc_evt_status_chk.sv
module rtc_evt_status_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_evt,
  input logic              alm_evt,
  input logic              per_evt,
  input logic              upd_en,
  input logic              evt_rd,
  input logic              integ_rd,
  input logic              bkp_ok,
  input logic [BYTE_W-1:0] evt_byte,
  input logic [BYTE_W-1:0] integ_byte,
  input logic              irq_n
);
  // R3
  evt_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    evt_byte[BYTE_W-5:0] == '0);

  // R8
  integ_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    integ_byte[BYTE_W-2:0] == '0);

  // R8
  integ_cap_chk: assert property (@(posedge clk) disable iff (rst)
    integ_rd |=> integ_byte[BYTE_W-1] == $past(bkp_ok));

  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_rd |=> $stable(evt_byte));

  // R9
  integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !integ_rd |=> $stable(integ_byte));

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_rd && !upd_evt && !alm_evt && !per_evt) |=> irq_n);

  // R5
  upd_irq_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> (!upd_en || !irq_n));
endmodule

bind rtc_evt_status rtc_evt_status_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_evt    (upd_evt),
  .alm_evt    (alm_evt),
  .per_evt    (per_evt),
  .upd_en     (upd_en),
  .evt_rd     (evt_rd),
  .integ_rd   (integ_rd),
  .bkp_ok     (bkp_ok),
  .evt_byte   (evt_byte),
  .integ_byte (integ_byte),
  .irq_n      (irq_n)
);

// File: tb/test_rtc_evt_status.sv
module test_rtc_evt_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_evt = 0, alm_evt = 0, per_evt = 0;
  logic upd_en = 0, alm_en = 0, per_en = 0;
  logic evt_rd = 0, integ_rd = 0, bkp_ok = 0;
  logic [7:0] evt_byte, integ_byte;
  logic irq_n;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rtc_evt_status i_rtc_evt_status (
    .clk(clk), .rst(rst),
    .upd_evt(upd_evt), .alm_evt(alm_evt), .per_evt(per_evt),
    .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en),
    .evt_rd(evt_rd), .integ_rd(integ_rd), .bkp_ok(bkp_ok),
    .evt_byte(evt_byte), .integ_byte(integ_byte), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // m[0]=update, m[1]=alarm, m[2]=periodic
  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    {per_evt, alm_evt, upd_evt} = m;
    @(negedge clk);
    {per_evt, alm_evt, upd_evt} = 3'b000;
  endtask

  task automatic set_en(input logic [2:0] e);
    @(negedge clk);
    {per_en, alm_en, upd_en} = e;
    #1;
  endtask

  // Read strobe for one edge, with an optional coincident pulse mask.
  task automatic rd_evt(input logic [2:0] m);
    @(negedge clk);
    evt_rd = 1'b1;
    {per_evt, alm_evt, upd_evt} = m;
    @(negedge clk);
    evt_rd = 1'b0;
    {per_evt, alm_evt, upd_evt} = 3'b000;
  endtask

  task automatic rd_integ(input logic v);
    @(negedge clk);
    integ_rd = 1'b1;
    bkp_ok = v;
    @(negedge clk);
    integ_rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] m, input logic [2:0] e);
    return {|(m & e), m[2], m[1], m[0], 4'b0000};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 00 expected 01");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 evt_byte", evt_byte, 8'h00);
    chk("R1 integ_byte", integ_byte, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

    // Sweep over all pulse masks and enable masks.
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 8; e++) begin
        set_en(3'b000);
        pulse(m[2:0]);
        #1;
        chk("R2 flags latched with enables off, irq_n", {7'b0, irq_n}, 8'h01);
        set_en(e[2:0]);
        chk("R5 irq_n follows enable", {7'b0, irq_n}, {7'b0, ~|(m[2:0] & e[2:0])});
        rd_evt(3'b000);
        chk("R3 R4 event byte", evt_byte, exp_byte(m[2:0], e[2:0]));
        chk("R6 irq_n after read", {7'b0, irq_n}, 8'h01);
        rd_evt(3'b000);
        chk("R6 second read", evt_byte, 8'h00);
      end
    end

    // R7: pulse coincides with read.
    for (int m = 1; m < 8; m++) begin
      set_en(3'b111);
      pulse(3'b000);
      rd_evt(m[2:0]);
      chk("R7 read shows pre-event value", evt_byte, 8'h00);
      chk("R7 irq_n after coincident pulse", {7'b0, irq_n}, 8'h00);
      rd_evt(3'b000);
      chk("R7 flag kept", evt_byte, exp_byte(m[2:0], 3'b111));
    end

    // R8, R10: integrity reads.
    set_en(3'b111);
    pulse(3'b010);
    #1;
    rd_integ(1'b1);
    chk("R8 valid", integ_byte, 8'h80);
    chk("R10 irq_n unchanged", {7'b0, irq_n}, 8'h00);
    bkp_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 integ held", integ_byte, 8'h80);
    rd_integ(1'b0);
    chk("R8 depleted", integ_byte, 8'h00);
    chk("R9 evt_byte held", evt_byte, exp_byte(3'b111, 3'b111));
    rd_evt(3'b000);
    chk("R10 flag survives integ read", evt_byte, 8'hA0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule